// File: doc/BRIEF.md
# Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken, working from the branch address alone. The guess comes from two levels of state. The first level holds shift registers of recent branch outcomes. The second level is a table of saturating up/down counters, and the first level's history selects a row of it. The design has four sizing parameters. `HIST_ADDR_BITS` is the number of address bits that pick a history register; when it is zero there is one global history. `HIST_LEN` is the history length. `COL_BITS` is the number of address bits that pick a counter column. `CTR_W` is the counter width. The storage is `HIST_LEN * 2^HIST_ADDR_BITS` history bits plus `2^HIST_LEN * 2^COL_BITS * CTR_W` counter bits.

The fetch stage presents a PC on the lookup port and receives a taken/not-taken guess in the same cycle. When the branch resolves, the pipeline reports the branch's PC and its real outcome on the update port. The update trains the counter that the branch used and then records the outcome in the branch's history. The parameter `INDEX_MODE` selects how the row is formed. It can use the history directly, or it can XOR the history with the low address bits.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset, every counter holds the weak not-taken value 2^(CTR_W-1)-1 (01 when CTR_W=2) and every history is zero. Every lookup therefore predicts not taken until an update arrives.
- R2: When HIST_ADDR_BITS > 0, each branch reads and writes only the history register selected by pc[HIST_ADDR_BITS-1:0]. Branches that differ in those bits do not disturb each other's history.
- R3: When HIST_ADDR_BITS = 0, a single global history is read and shifted by every branch, whatever its address.
- R4: The counter index is row * 2^COL_BITS + pc[COL_BITS-1:0]. In concatenation mode the row is the history. In XOR mode the row is the history XOR pc[HIST_LEN-1:0].
- R5: A taken update increments the selected counter and a not-taken update decrements it. The counter stays at 2^CTR_W-1 on further taken updates and at 0 on further not-taken updates.
- R6: A lookup predicts taken exactly when its counter is at least 2^(CTR_W-1). For CTR_W=2, the states 10 and 11 predict taken.
- R7: The lookup output is combinational from the lookup PC. An update in the same cycle becomes visible only after the next rising clock edge.
- R8: An update computes its counter index from the history value before the shift. The history then shifts left by one place, the actual outcome enters bit 0, and the oldest bit is dropped.
- R9: In a cycle without an update, no counter and no history changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Predicted direction for lk_pc, 1 = taken |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The hardest case to reach from the ports is a counter reaching saturation at a single index while the history is still moving. Every update shifts the history, so repeated outcomes on one address land on a new row each time. A counter only stops moving once the history has filled with a constant pattern.

The stimulus reaches this case in two ways. Long runs of identical outcomes on one address first fill the history with a constant pattern and then drive the counter against both rails. Short repeating loop patterns make the history cycle through a few fixed values. Three instances (per-address, global, and XOR-hashed) share the same stimulus. Each is compared on every cycle against a behavioural model, both during these runs and during random traffic confined to a few aliasing addresses.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    // How the pattern-table row is formed from the history
    typedef enum logic {
        IDX_CONCAT = 1'b0,   // row = history
        IDX_XOR    = 1'b1    // row = history ^ low address bits
    } index_mode_e;

endpackage

// File: rtl/bdp_history_store.sv
module bdp_history_store #(
    parameter int PC_W     = 16,
    parameter int SEL_BITS = 2,
    parameter int HLEN     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] rd_pc,
    output logic [HLEN-1:0] rd_hist,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic            wr_taken,
    output logic [HLEN-1:0] wr_hist
);
    localparam int ENTRIES = 1 << SEL_BITS;
    localparam int SEL_W   = (SEL_BITS > 0) ? SEL_BITS : 1;

    typedef struct packed {
        logic [ENTRIES-1:0][HLEN-1:0] hist;
    } hs_state_t;

    hs_state_t       s_d, s_q;
    logic [SEL_W-1:0] rd_sel, wr_sel;

    generate
        if (SEL_BITS > 0) begin : g_per_addr
            assign rd_sel = rd_pc[SEL_W-1:0];
            assign wr_sel = wr_pc[SEL_W-1:0];
        end else begin : g_global
            assign rd_sel = '0;
            assign wr_sel = '0;
        end
    endgenerate

    assign rd_hist = s_q.hist[rd_sel];
    assign wr_hist = s_q.hist[wr_sel];

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.hist[wr_sel] = {s_q.hist[wr_sel][HLEN-2:0], wr_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.hist <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8: outcome enters at bit 0, older bits move up by one
    a_r8_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> s_q.hist[$past(wr_sel)] == {$past(wr_hist[HLEN-2:0]), $past(wr_taken)});

    // R9: histories hold when nothing is reported
    a_r9_hist_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.hist));

endmodule

// File: rtl/bdp_pattern_table.sv
module bdp_pattern_table #(
    parameter int ROW_W = 4,
    parameter int COL_W = 2,
    parameter int CTR_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ROW_W+COL_W-1:0] rd_idx,
    output logic [CTR_W-1:0]       rd_ctr,
    input  logic                   wr_en,
    input  logic [ROW_W+COL_W-1:0] wr_idx,
    input  logic                   wr_taken
);
    localparam int IDX_W = ROW_W + COL_W;
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_ZERO = '0;
    localparam logic [CTR_W-1:0] CTR_ONE  = CTR_W'(1);
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

    typedef struct packed {
        logic [DEPTH-1:0][CTR_W-1:0] ctr;
    } pt_state_t;

    pt_state_t        s_d, s_q;
    logic [CTR_W-1:0] old_ctr;

    assign rd_ctr  = s_q.ctr[rd_idx];
    assign old_ctr = s_q.ctr[wr_idx];

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (wr_taken && old_ctr != CTR_MAX) begin
                s_d.ctr[wr_idx] = old_ctr + CTR_ONE;
            end else if (!wr_taken && old_ctr != CTR_ZERO) begin
                s_d.ctr[wr_idx] = old_ctr - CTR_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ctr <= {DEPTH{CTR_INIT}};
        end else begin
            s_q <= s_d;
        end
    end

    // R5: taken moves the counter up by one below the top rail
    a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && old_ctr != CTR_MAX)
        |=> s_q.ctr[$past(wr_idx)] == $past(old_ctr) + CTR_ONE);

    // R5: not-taken moves the counter down by one above the bottom rail
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && old_ctr != CTR_ZERO)
        |=> s_q.ctr[$past(wr_idx)] == $past(old_ctr) - CTR_ONE);

    // R5: rails hold
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_taken && old_ctr == CTR_MAX) || (!wr_taken && old_ctr == CTR_ZERO)))
        |=> $stable(s_q.ctr));

    // R9: table holds when nothing is reported
    a_r9_ctr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.ctr));

endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
    parameter int                  PC_W           = 16,
    parameter int                  HIST_ADDR_BITS = 2,
    parameter int                  HIST_LEN       = 4,
    parameter int                  COL_BITS       = 2,
    parameter int                  CTR_W          = 2,
    parameter bdp_pkg::index_mode_e INDEX_MODE    = bdp_pkg::IDX_CONCAT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int IDX_W = HIST_LEN + COL_BITS;

    logic [HIST_LEN-1:0] lk_hist, up_hist;
    logic [HIST_LEN-1:0] lk_row, up_row;
    logic [IDX_W-1:0]    lk_idx, up_idx;
    logic [CTR_W-1:0]    lk_ctr;

    bdp_history_store #(
        .PC_W     (PC_W),
        .SEL_BITS (HIST_ADDR_BITS),
        .HLEN     (HIST_LEN)
    ) i_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pc    (lk_pc),
        .rd_hist  (lk_hist),
        .wr_en    (up_valid),
        .wr_pc    (up_pc),
        .wr_taken (up_taken),
        .wr_hist  (up_hist)
    );

    generate
        if (INDEX_MODE == bdp_pkg::IDX_XOR) begin : g_hash
            assign lk_row = lk_hist ^ lk_pc[HIST_LEN-1:0];
            assign up_row = up_hist ^ up_pc[HIST_LEN-1:0];
        end else begin : g_concat
            assign lk_row = lk_hist;
            assign up_row = up_hist;
        end
    endgenerate

    assign lk_idx = {lk_row, lk_pc[COL_BITS-1:0]};
    assign up_idx = {up_row, up_pc[COL_BITS-1:0]};

    bdp_pattern_table #(
        .ROW_W (HIST_LEN),
        .COL_W (COL_BITS),
        .CTR_W (CTR_W)
    ) i_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    // counter upper half predicts taken
    assign lk_taken = lk_ctr[CTR_W-1];

endmodule

// File: tb/test_branch_dir_predictor.sv
module test_branch_dir_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int NCFG = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lk_pc = '0;
    logic [15:0] up_pc = '0;
    logic        up_valid = 1'b0;
    logic        up_taken = 1'b0;
    logic        pred0, pred1, pred2;

    int checks = 0;
    int errors = 0;
    int hist_m [NCFG][4];
    int ctr_m  [NCFG][64];
    string cfg_tag [NCFG] = '{"R2", "R3", "R4"};

    always #(CLK_PERIOD/2) clk = ~clk;

    // per-address history, concatenated index
    branch_dir_predictor #(.HIST_ADDR_BITS(2), .INDEX_MODE(bdp_pkg::IDX_CONCAT)) i_branch_dir_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred0),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    // global history, concatenated index
    branch_dir_predictor #(.HIST_ADDR_BITS(0), .INDEX_MODE(bdp_pkg::IDX_CONCAT)) i_branch_dir_predictor_glob (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred1),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    // global history, XOR-hashed index
    branch_dir_predictor #(.HIST_ADDR_BITS(0), .INDEX_MODE(bdp_pkg::IDX_XOR)) i_branch_dir_predictor_hash (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred2),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    function automatic int hsel(int c, logic [15:0] pc);
        return (c == 0) ? int'(pc[1:0]) : 0;
    endfunction

    function automatic int midx(int c, logic [15:0] pc, int h);
        int row;
        row = (c == 2) ? (h ^ int'(pc[3:0])) : h;
        return row * 4 + int'(pc[1:0]);
    endfunction

    function automatic logic mpred(int c, logic [15:0] pc);
        return ctr_m[c][midx(c, pc, hist_m[c][hsel(c, pc)])] >= 2;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCFG; c++) begin
            for (int i = 0; i < 4; i++) hist_m[c][i] = 0;
            for (int i = 0; i < 64; i++) ctr_m[c][i] = 1;
        end
    endtask

    task automatic check(string req, int c, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cfg%0d pc=%h actual=%b expected=%b", req, c, lk_pc, act, exp);
        end
    endtask

    task automatic step(logic [15:0] lpc, logic uv, logic [15:0] upc, logic ut, string req);
        logic act;
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
        #1;
        for (int c = 0; c < NCFG; c++) begin
            act = (c == 0) ? pred0 : (c == 1) ? pred1 : pred2;
            check((req == "") ? cfg_tag[c] : req, c, act, mpred(c, lpc));
        end
        if (uv) begin
            for (int c = 0; c < NCFG; c++) begin
                int hi, h, ix;
                hi = hsel(c, upc);
                h  = hist_m[c][hi];
                ix = midx(c, upc, h);            // R8: pre-shift history
                if (ut && ctr_m[c][ix] < 3) ctr_m[c][ix]++;
                else if (!ut && ctr_m[c][ix] > 0) ctr_m[c][ix]--;
                hist_m[c][hi] = ((h << 1) | int'(ut)) & 15;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all lookups predict not taken after reset
        for (int p = 0; p < 32; p++) step(16'(p), 1'b0, '0, 1'b0, "R1");

        // R9: stimulus on update address/outcome without valid changes nothing
        for (int i = 0; i < 20; i++)
            step(16'($urandom % 16), 1'b0, 16'($urandom % 16), 1'($urandom), "R9");

        // R5: long runs against both rails on one address
        for (int i = 0; i < 10; i++) step(16'h0, 1'b1, 16'h0, 1'b1, "R5");
        for (int i = 0; i < 10; i++) step(16'h0, 1'b1, 16'h0, 1'b0, "R5");
        for (int i = 0; i < 10; i++) step(16'h0, 1'b1, 16'h0, 1'b1, "R5");

        // R6: loop-closing branch TTTN
        for (int i = 0; i < 40; i++) step(16'h21, 1'b1, 16'h21, (i % 4) != 3, "R6");

        // R7: lookup and update on the same address in the same cycle
        for (int i = 0; i < 40; i++) begin
            logic [15:0] pc;
            pc = 16'($urandom % 8);
            step(pc, 1'b1, pc, 1'($urandom), "R7");
        end

        // R2: two addresses with opposite behaviour
        for (int i = 0; i < 30; i++) begin
            step(16'h1, 1'b1, 16'h1, 1'b1, "R2");
            step(16'h2, 1'b1, 16'h2, 1'b0, "R2");
        end

        // R8: interleaved addresses with lookups elsewhere
        for (int i = 0; i < 60; i++)
            step(16'($urandom % 16), 1'b1, 16'($urandom % 6), 1'($urandom % 3 != 0), "R8");

        // R2/R3/R4 per configuration: random aliasing traffic
        for (int i = 0; i < 600; i++)
            step(16'($urandom % 16), 1'($urandom % 4 != 0), 16'($urandom % 16), 1'($urandom), "");

        // R4: hashed rows across all columns
        for (int i = 0; i < 100; i++)
            step(16'($urandom), 1'b1, 16'($urandom % 32), 1'($urandom % 4 != 0), "R4");

        @(negedge clk);
        up_valid = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule